// File: doc/BRIEF.md
# Two-Phase Serial Register Port

This block is a serial slave that lets an external host read and write a small bank of 8-bit control registers. The host uses three wires: an active-low chip-select, a serial clock and one data line that carries data in both directions. Every transaction opens with an instruction byte. That byte gives the direction, the number of data bytes (one to four) and the starting register address. The data bytes follow, and the address steps down by one after each byte. Internal logic sees every register at all times through a flat parallel output.

The serial inputs are synchronised into the core clock, and their edges are found by oversampling, so the serial clock must run several times slower than the core clock. The bidirectional line is split into an input, an output and an output enable, and the pad logic above the block combines them. A write byte lands in its register only once all eight of its bits have arrived. If chip-select rises early, the unfinished byte is dropped and the state of the port is cleared.

Top module: `spi_regport`

## Requirements
- R1: After reset, register k holds ((29*k) mod 256) XOR 0xA5 and the output enable is low.
- R2: The first eight rising serial-clock edges after chip-select falls shift in the instruction byte, MSB first. Bit 7 = 1 means read and 0 means write, bits 6:5 give the byte count minus one, and bits 4:0 give the starting address.
- R3: During a write, each data byte is sampled MSB first on rising edges and is committed to the addressed register once its eighth bit arrives.
- R4: A transfer moves exactly count bytes. Byte j goes to or comes from address (start − j) mod 32.
- R5: Serial-clock edges that come after the last counted byte change no register.
- R6: During a read, the data line carries register bits MSB first and changes on falling edges. The first bit appears after the instruction's eighth rising edge. The output enable is high only in the data phase of a read.
- R7: If chip-select rises in the middle of a data byte, that byte is discarded. Bytes that finished earlier in the same transfer stay written.
- R8: If chip-select rises during the instruction byte, no register is written, and the next transaction works normally.
- R9: Addresses at or above NUM_REGS ignore writes and read back as zero.
- R10: The parallel output presents register k on bits [8k+7:8k].
- R11: The output enable is low whenever chip-select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip-select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Serial data, input side of the pad |
| sdio_o | output | 1 | Serial read data, output side of the pad |
| sdio_oe_o | output | 1 | Output enable for the data pad |
| regs_o | output | 8*NUM_REGS | Parallel view of all registers |

## Verification
The bench writes to and reads from every one of the 32 addresses, so the unmapped half must ignore writes and return zero. If the decode were wrong, some register would be overwritten or the read data would not be zero. Multi-byte transfers that start at addresses 0, 1 and 2 force the address to wrap from 0 to 31. If the decrement or the byte counter were wrong, data would land in a neighbouring register or the transfer would run one byte too long or too short. Chip-select is raised partway through an instruction byte and partway through a data byte. A design that committed partial bytes, or that failed to clear its state, would corrupt a register or misread the next transaction. Extra clocks after the counted bytes would expose a port that keeps writing or keeps driving the data line.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_DONE} phase_e;

  typedef struct packed {
    logic              rd;
    logic [1:0]        len_m1;
    logic [ADDR_W-1:0] addr;
  } instr_t;

  function automatic logic [BYTE_W-1:0] reg_default(input int unsigned idx);
    return BYTE_W'((idx * 29) ^ 32'hA5);
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned       WIDTH     = 3,
  parameter int unsigned       STAGES    = 2,
  parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RESET_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_regport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  phase_e            phase_q;
  logic [2:0]        bit_cnt_q;
  logic [1:0]        byte_idx_q;
  logic [6:0]        shift_q;
  instr_t            instr_q;
  logic [ADDR_W-1:0] addr_q;
  logic              sdo_q;
  logic [BYTE_W-1:0] full_byte;
  logic              byte_done;

  assign full_byte = {shift_q, sdi_i};
  assign byte_done = cs_act_i && rise_i && (bit_cnt_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_INSTR;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      shift_q    <= '0;
      instr_q    <= '0;
      addr_q     <= '0;
      sdo_q      <= 1'b0;
    end else if (!cs_act_i) begin
      // chip-select high: drop any partial frame
      phase_q    <= PH_INSTR;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      sdo_q      <= 1'b0;
    end else begin
      if (rise_i && phase_q != PH_DONE) begin
        shift_q   <= full_byte[6:0];
        bit_cnt_q <= bit_cnt_q + 3'd1;
        if (bit_cnt_q == 3'd7) begin
          if (phase_q == PH_INSTR) begin
            instr_q    <= instr_t'(full_byte);
            addr_q     <= full_byte[ADDR_W-1:0];
            byte_idx_q <= '0;
            phase_q    <= PH_DATA;
          end else begin
            addr_q     <= addr_q - ADDR_W'(1);
            byte_idx_q <= byte_idx_q + 2'd1;
            if (byte_idx_q == instr_q.len_m1) phase_q <= PH_DONE;
          end
        end
      end
      if (fall_i && phase_q == PH_DATA && instr_q.rd)
        sdo_q <= rd_data_i[3'd7 - bit_cnt_q];
    end
  end

  assign wr_en_o   = byte_done && phase_q == PH_DATA && !instr_q.rd;
  assign addr_o    = addr_q;
  assign wr_data_o = full_byte;
  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = cs_act_i && phase_q == PH_DATA && instr_q.rd;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regport_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [BYTE_W-1:0]          wr_data_i,
  output logic [BYTE_W-1:0]          rd_data_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic [BYTE_W-1:0] regs_q [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[k] <= reg_default(k);
      else if (wr_en_i && addr_i == ADDR_W'(k)) regs_q[k] <= wr_data_i;
    end
    assign regs_o[k*BYTE_W +: BYTE_W] = regs_q[k];
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (addr_i == ADDR_W'(k)) rd_data_o = regs_q[k];
  end
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_ni,
  input  logic                       sclk_i,
  input  logic                       sdio_i,
  output logic                       sdio_o,
  output logic                       sdio_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic [2:0]        sync_q;
  logic              cs_act, sclk_s, sdi_s, sclk_q, sclk_rise, sclk_fall;
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  spi_in_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({cs_ni, sclk_i, sdio_i}), .q_o(sync_q)
  );

  assign cs_act = ~sync_q[2];
  assign sclk_s = sync_q[1];
  assign sdi_s  = sync_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else sclk_q <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;

  spi_frame_ctrl u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_act_i(cs_act),
    .rise_i(sclk_rise), .fall_i(sclk_fall), .sdi_i(sdi_s),
    .rd_data_i(rd_data), .wr_en_o(wr_en), .addr_o(addr),
    .wr_data_o(wr_data), .sdo_o(sdio_o), .sdo_oe_o(sdio_oe_o)
  );

  spi_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .regs_o(regs_o)
  );
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
  parameter int unsigned NUM_REGS = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cs_act,
  input logic                  sclk_rise,
  input logic                  wr_en,
  input logic                  sdio_oe_o,
  input logic [NUM_REGS*8-1:0] regs_o
);
  logic [NUM_REGS*8-1:0] prev_q;
  logic                  prev_vld_q;
  logic [NUM_REGS-1:0]   chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else begin
      prev_q     <= regs_o;
      prev_vld_q <= 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_chg
    assign chg[k] = prev_q[k*8 +: 8] != regs_o[k*8 +: 8];
  end

  p_oe_needs_cs_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> cs_act);
  p_write_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (sclk_rise && cs_act && !sdio_oe_o));
  p_idle_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> $stable(regs_o));
  p_single_update_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_vld_q |-> $countones(chg) <= 1);
endmodule

bind spi_regport spi_regport_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_act(cs_act), .sclk_rise(sclk_rise),
  .wr_en(wr_en), .sdio_oe_o(sdio_oe_o), .regs_o(regs_o)
);

// File: tb/spi_regport_bench.sv
module spi_regport_bench;
  localparam int NUM_REGS = 16;
  localparam int HP = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cs_n, sclk, sdi, sdo, oe;
  logic [NUM_REGS*8-1:0] regs;

  spi_regport #(.NUM_REGS(NUM_REGS)) u_spi_regport (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk),
    .sdio_i(sdi), .sdio_o(sdo), .sdio_oe_o(oe), .regs_o(regs)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_regs [NUM_REGS];
  logic [7:0] wbuf [5];
  logic [7:0] rbuf [4];
  bit oe_bad, oe_extra;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] model_rd(input int a);
    return (a < NUM_REGS) ? exp_regs[a] : 8'h00;
  endfunction

  task automatic check_all(input string req);
    for (int k = 0; k < NUM_REGS; k++)
      chk(regs[k*8 +: 8] == exp_regs[k], req, regs[k*8 +: 8], exp_regs[k]);
  endtask

  task automatic xfer(input logic [7:0] instr, input int nbits);
    int nb;
    nb = int'(instr[6:5]) + 1;
    oe_bad = 0; oe_extra = 0;
    cs_n = 1'b0;
    tick(HP);
    for (int i = 0; i < nbits; i++) begin
      int bi, bp;
      bi = (i - 8) / 8; bp = 7 - ((i - 8) % 8);
      sdi = (i < 8) ? instr[7-i] : wbuf[bi][bp];
      tick(HP);
      if (i >= 8) begin
        if (instr[7] && bi < nb) begin
          rbuf[bi][bp] = sdo;
          if (!oe) oe_bad = 1;
        end else if (oe) begin
          if (instr[7]) oe_extra = 1; else oe_bad = 1;
        end
      end
      sclk = 1'b1;
      tick(HP);
      sclk = 1'b0;
    end
    tick(HP);
    cs_n = 1'b1;
    tick(4*HP);
    chk(oe == 1'b0, "R11 oe after cs high", oe, 0);
  endtask

  task automatic wr(input int addr, input int n);
    xfer({1'b0, 2'(n-1), 5'(addr)}, 8 + 8*n);
    for (int j = 0; j < n; j++) begin
      int a;
      a = (addr - j) & 31;
      if (a < NUM_REGS) exp_regs[a] = wbuf[j];
    end
    chk(!oe_bad, "R6 oe during write", oe_bad, 0);
  endtask

  task automatic rd(input int addr, input int n, input string req);
    xfer({1'b1, 2'(n-1), 5'(addr)}, 8 + 8*n);
    for (int j = 0; j < n; j++)
      chk(rbuf[j] == model_rd((addr - j) & 31), req, rbuf[j], model_rd((addr - j) & 31));
    chk(!oe_bad, "R6 oe in read data phase", oe_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cs_n = 1; sclk = 0; sdi = 0;
    for (int k = 0; k < NUM_REGS; k++) exp_regs[k] = 8'((k*29) ^ 8'hA5);
    tick(5);
    rst_n = 1;
    tick(5);
    check_all("R1 R10 reset defaults");
    chk(oe == 1'b0, "R1 oe at reset", oe, 0);

    // R2 R3 R9: single-byte writes over all 32 addresses
    for (int a = 0; a < 32; a++) begin
      wbuf[0] = 8'(a*53 + 7);
      wr(a, 1);
      check_all("R3 R9 single write");
    end
    for (int a = 0; a < 32; a++) rd(a, 1, "R6 R9 single read");

    // R4: multi-byte with wrap
    for (int n = 1; n <= 4; n++) begin
      int starts [7] = '{0, 1, 2, 7, 15, 31, 20};
      foreach (starts[s]) begin
        for (int j = 0; j < 4; j++) wbuf[j] = 8'(n*17 + starts[s]*3 + j*101);
        wr(starts[s], n);
        check_all("R4 multi write");
        rd(starts[s], n, "R4 multi read");
      end
    end

    // R5: extra byte after count
    wbuf[0] = 8'h3C; wbuf[1] = 8'hC3;
    xfer({1'b0, 2'd0, 5'd5}, 24);
    exp_regs[5] = 8'h3C;
    check_all("R5 extra write byte");
    xfer({1'b1, 2'd0, 5'd4}, 24);
    chk(rbuf[0] == exp_regs[4], "R5 read with extra clocks", rbuf[0], exp_regs[4]);
    chk(!oe_extra, "R6 oe after last read byte", oe_extra, 0);

    // R7: abort inside second data byte
    wbuf[0] = 8'h5A; wbuf[1] = 8'h96;
    xfer({1'b0, 2'd1, 5'd9}, 8 + 8 + 4);
    exp_regs[9] = 8'h5A;
    check_all("R7 abort mid data byte");

    // R8: abort inside instruction
    wbuf[0] = 8'hFF;
    xfer({1'b0, 2'd0, 5'd3}, 5);
    check_all("R8 abort in instruction");
    rd(3, 1, "R8 recovery read");
    wbuf[0] = 8'h81;
    wr(3, 1);
    check_all("R8 recovery write");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule